// File: doc/BRIEF.md
# Scanline Access Slot Timing Generator

This block runs on the master clock and divides every scanline of a video frame into memory access slots. At the start of each slot it reports what the slot is for. On an active line with the display switched on, every slot goes to the renderer. On a blanking line, or on any line while the display is switched off, a slot is either a memory refresh slot at a fixed index or an external slot, which the write queue in front of video memory may use. The block counts lines, wraps them at the end of the frame, and latches the horizontal and vertical timing modes once per frame.

When the display is off during an active line other than line 0, the block also flags the slots where a 16-pixel strip of the previous line should be filled with the background colour. It gives the line, the horizontal pixel position and the 6-bit colour for each fill. Pixel rendering and the contents of memory are handled elsewhere. This block only produces the slot schedule.

Top module: `scanline_slot_timer`

## Requirements
- R1: A line is `LINE_CLKS` (3420) master clocks long. `lineNum` advances by one at each line boundary. After the last line of the frame (`NTSC_FRAME`=262 lines, or `PAL_FRAME`=313 when the latched PAL mode is set) it returns to 0.
- R2: A slot is 20 master clocks in narrow mode and 16 in wide mode. The slot index restarts at 0 on each line, so a line has slots 0..170 in narrow mode and slots 0..213 in wide mode. The last wide slot is 12 clocks long.
- R3: The timing mode is sampled only on the first master clock of line 0. `modeReg4` bit 0 set selects wide mode, and `modeReg2` bit 3 set selects PAL. Changes to these bits at any other time have no effect until the next frame. `wideMode` and `palMode` show the latched values.
- R4: A line is active when `lineNum` is below `NTSC_ACTIVE` (225) or `PAL_ACTIVE` (241). The display enable is `modeReg2` bit 6, read live. On an active line with the display enabled, every slot start gives `renderSlot`, and no refresh or external slot occurs.
- R5: Outside the render case, `refreshSlot` pulses at wide-mode slot indices 73, 105, 137, 169 and 201, and at narrow-mode slot indices 66, 98, 130 and 162.
- R6: Outside the render case, every slot start that is not a refresh slot gives `externalSlot`.
- R7: On an active line above 0 with the display disabled, `fillStrobe` pulses at slots 55, 63, …, 207 in wide mode (20 fills) and at slots 48, 56, …, 168 in narrow mode (16 fills). With each pulse, `fillLine` is the current line minus 1, `fillX` is 2 × (slot − first fill slot), and `fillColor` is `bgColorReg[5:0]`. These fields are 0 when there is no fill.
- R8: All outputs are registered. The slot indications appear for exactly one clock, in the cycle after the slot's first master clock. During reset every output is 0.
- R9: At most one of `renderSlot`, `refreshSlot` and `externalSlot` is high in any cycle. A fill always falls on a refresh or external slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeReg2 | input | 8 | Mode register 2 (bit 6 display enable, bit 3 PAL) |
| modeReg4 | input | 8 | Mode register 4 (bit 0 wide mode) |
| bgColorReg | input | 8 | Background colour register (low 6 bits used) |
| lineNum | output | LINE_W | Line of the current master clock |
| slotIdx | output | SLOT_W | Slot index within the line |
| wideMode | output | 1 | Latched wide mode |
| palMode | output | 1 | Latched PAL mode |
| renderSlot | output | 1 | Slot start granted to rendering |
| refreshSlot | output | 1 | Slot start reserved for refresh |
| externalSlot | output | 1 | Slot start granted to the write queue |
| fillStrobe | output | 1 | Background fill of 16 pixels due |
| fillLine | output | LINE_W | Line the fill targets |
| fillX | output | PIX_W | First pixel of the fill strip |
| fillColor | output | 6 | Fill colour index |

## Verification
The bench models every master clock from the requirements and compares all outputs each cycle. It also counts the slots of each class per line. Several corner cases are targeted directly:
- The partial last slot in wide mode. A design that rounded the line to 213 or 215 slots would shift the count of external slots away from 209.
- Mode bits changed in the middle of a frame. A design that latched them continuously would switch the slot width and the frame length one frame early.
- The fill on line 0 and the first and last fill positions in both modes. A wrong base slot or a wrong line offset would move `fillX` away from 0..304 (wide) or 0..240 (narrow), or move `fillLine`.
- The frame wrap in both NTSC and PAL timing, which would break if the wrong frame length were chosen at the last line.

// File: rtl/scan_slot_pkg.sv
package scan_slot_pkg;

  // bit positions inside the mode and colour registers
  localparam int WIDE_BIT   = 0;  // modeReg4
  localparam int PAL_BIT    = 3;  // modeReg2
  localparam int DISP_BIT   = 6;  // modeReg2
  localparam int COLOUR_W   = 6;

  // strobes passed from the counters to the classifier
  typedef struct packed {
    logic slotStart;   // first master clock of a slot
    logic frameStart;  // first master clock of line 0
    logic wide;        // mode in force for this clock
    logic pal;
  } slot_strobe_t;

endpackage

// File: rtl/scan_slot_refresh_match.sv
module scan_slot_refresh_match #(
  parameter int SLOT_W = 8,
  parameter int BASE   = 73,
  parameter int STEP   = 32,
  parameter int COUNT  = 5
) (
  input  logic [SLOT_W-1:0] slot,
  output logic              hit
);
  logic [COUNT-1:0] eq;

  for (genvar k = 0; k < COUNT; k++) begin : g_cmp
    assign eq[k] = (slot == SLOT_W'(BASE + k * STEP));
  end

  assign hit = |eq;
endmodule

// File: rtl/scan_slot_ctrl.sv
module scan_slot_ctrl
  import scan_slot_pkg::*;
#(
  parameter int LINE_CLKS   = 3420,
  parameter int WIDE_CLKS   = 16,
  parameter int NARROW_CLKS = 20,
  parameter int NTSC_FRAME  = 262,
  parameter int PAL_FRAME   = 313,
  parameter int LINE_W      = 9,
  parameter int SLOT_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        modeReg2,
  input  logic [7:0]        modeReg4,
  output slot_strobe_t      strobe,
  output logic [SLOT_W-1:0] slotCnt,
  output logic [LINE_W-1:0] lineCnt
);
  localparam int CYC_W   = $clog2(LINE_CLKS);
  localparam int MAX_SLT = (WIDE_CLKS > NARROW_CLKS) ? WIDE_CLKS : NARROW_CLKS;
  localparam int SUB_W   = $clog2(MAX_SLT);

  logic [CYC_W-1:0]  lineCyc;
  logic [SUB_W-1:0]  subCnt;
  logic              wideQ, palQ;
  logic              frameStart, wideEff, palEff;
  logic [SUB_W-1:0]  subLast;
  logic [LINE_W-1:0] frameLast;
  logic              lineEnd;

  assign frameStart = (lineCnt == '0) && (lineCyc == '0);
  assign wideEff    = frameStart ? modeReg4[WIDE_BIT] : wideQ;
  assign palEff     = frameStart ? modeReg2[PAL_BIT]  : palQ;
  assign subLast    = wideEff ? SUB_W'(WIDE_CLKS - 1) : SUB_W'(NARROW_CLKS - 1);
  assign frameLast  = palEff ? LINE_W'(PAL_FRAME - 1) : LINE_W'(NTSC_FRAME - 1);
  assign lineEnd    = (lineCyc == CYC_W'(LINE_CLKS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCyc <= '0;
      subCnt  <= '0;
      slotCnt <= '0;
      lineCnt <= '0;
      wideQ   <= 1'b0;
      palQ    <= 1'b0;
    end else begin
      wideQ <= wideEff;
      palQ  <= palEff;
      if (lineEnd) begin
        lineCyc <= '0;
        subCnt  <= '0;
        slotCnt <= '0;
        lineCnt <= (lineCnt == frameLast) ? '0 : lineCnt + 1'b1;
      end else begin
        lineCyc <= lineCyc + 1'b1;
        if (subCnt == subLast) begin
          subCnt  <= '0;
          slotCnt <= slotCnt + 1'b1;
        end else begin
          subCnt <= subCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.slotStart  = (subCnt == '0);
    strobe.frameStart = frameStart;
    strobe.wide       = wideEff;
    strobe.pal        = palEff;
  end

  // R1: the line counter restarts after its last clock
  a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rstN)
    lineEnd |=> (lineCyc == '0));

  // R1: the line number never passes the longest frame
  a_r1_frame_bound: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt <= LINE_W'(PAL_FRAME - 1));

  // R2: the sub-slot counter stays inside the slot width
  a_r2_sub_bound: assert property (@(posedge clk) disable iff (!rstN)
    subCnt <= subLast);

  // R3: the latched mode only moves at the frame start
  a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable({wideQ, palQ}));
endmodule

// File: rtl/scan_slot_datapath.sv
module scan_slot_datapath
  import scan_slot_pkg::*;
#(
  parameter int LINE_W        = 9,
  parameter int SLOT_W        = 8,
  parameter int PIX_W         = 9,
  parameter int NTSC_ACTIVE   = 225,
  parameter int PAL_ACTIVE    = 241,
  parameter int REF_STEP      = 32,
  parameter int REF_BASE_W    = 73,
  parameter int REF_CNT_W     = 5,
  parameter int REF_BASE_N    = 66,
  parameter int REF_CNT_N     = 4,
  parameter int FILL_FIRST_W  = 55,
  parameter int FILL_LAST_W   = 207,
  parameter int FILL_FIRST_N  = 48,
  parameter int FILL_LAST_N   = 168,
  parameter int FILL_STEP     = 8,
  parameter int FILL_PIXELS   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  slot_strobe_t        strobe,
  input  logic [SLOT_W-1:0]   slotCnt,
  input  logic [LINE_W-1:0]   lineCnt,
  input  logic [7:0]          modeReg2,
  input  logic [7:0]          bgColorReg,
  output logic [LINE_W-1:0]   lineNum,
  output logic [SLOT_W-1:0]   slotIdx,
  output logic                wideMode,
  output logic                palMode,
  output logic                renderSlot,
  output logic                refreshSlot,
  output logic                externalSlot,
  output logic                fillStrobe,
  output logic [LINE_W-1:0]   fillLine,
  output logic [PIX_W-1:0]    fillX,
  output logic [COLOUR_W-1:0] fillColor
);
  localparam int FILL_SHIFT = $clog2(FILL_STEP);
  localparam int PIX_SHIFT  = $clog2(FILL_PIXELS);

  logic hitWide, hitNarrow, refreshHit;
  logic lineActive, dispOn, renderCase;
  logic [SLOT_W-1:0] fillFirst, fillLast, fillOff;
  logic fillInRange, fillNow;
  logic renderNext, refreshNext, externalNext;
  logic [PIX_W-1:0] fillXNext;

  scan_slot_refresh_match #(
    .SLOT_W(SLOT_W), .BASE(REF_BASE_W), .STEP(REF_STEP), .COUNT(REF_CNT_W)
  ) u_refWide (
    .slot(slotCnt), .hit(hitWide)
  );

  scan_slot_refresh_match #(
    .SLOT_W(SLOT_W), .BASE(REF_BASE_N), .STEP(REF_STEP), .COUNT(REF_CNT_N)
  ) u_refNarrow (
    .slot(slotCnt), .hit(hitNarrow)
  );

  always_comb begin
    refreshHit   = strobe.wide ? hitWide : hitNarrow;
    lineActive   = strobe.pal ? (lineCnt < LINE_W'(PAL_ACTIVE))
                              : (lineCnt < LINE_W'(NTSC_ACTIVE));
    dispOn       = modeReg2[DISP_BIT];
    renderCase   = lineActive && dispOn;
    renderNext   = strobe.slotStart && renderCase;
    refreshNext  = strobe.slotStart && !renderCase && refreshHit;
    externalNext = strobe.slotStart && !renderCase && !refreshHit;

    fillFirst    = strobe.wide ? SLOT_W'(FILL_FIRST_W) : SLOT_W'(FILL_FIRST_N);
    fillLast     = strobe.wide ? SLOT_W'(FILL_LAST_W)  : SLOT_W'(FILL_LAST_N);
    fillOff      = slotCnt - fillFirst;
    fillInRange  = (slotCnt >= fillFirst) && (slotCnt <= fillLast) &&
                   (fillOff[FILL_SHIFT-1:0] == '0);
    fillNow      = strobe.slotStart && lineActive && !dispOn &&
                   (lineCnt != '0) && fillInRange;
    fillXNext    = PIX_W'(fillOff >> FILL_SHIFT) << PIX_SHIFT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineNum      <= '0;
      slotIdx      <= '0;
      wideMode     <= 1'b0;
      palMode      <= 1'b0;
      renderSlot   <= 1'b0;
      refreshSlot  <= 1'b0;
      externalSlot <= 1'b0;
      fillStrobe   <= 1'b0;
      fillLine     <= '0;
      fillX        <= '0;
      fillColor    <= '0;
    end else begin
      lineNum      <= lineCnt;
      slotIdx      <= slotCnt;
      wideMode     <= strobe.wide;
      palMode      <= strobe.pal;
      renderSlot   <= renderNext;
      refreshSlot  <= refreshNext;
      externalSlot <= externalNext;
      fillStrobe   <= fillNow;
      fillLine     <= fillNow ? lineCnt - 1'b1 : '0;
      fillX        <= fillNow ? fillXNext : '0;
      fillColor    <= fillNow ? bgColorReg[COLOUR_W-1:0] : '0;
    end
  end

  // R9: a slot has a single owner
  a_r9_one_class: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({renderSlot, refreshSlot, externalSlot}));

  // R9: fills only ride on slots not taken by rendering
  a_r9_fill_blank: assert property (@(posedge clk) disable iff (!rstN)
    fillStrobe |-> (refreshSlot || externalSlot));

  // R8: slot indications last one clock
  a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (renderSlot || refreshSlot || externalSlot) |=>
      !(renderSlot || refreshSlot || externalSlot));

  // R7: the fill never targets a line past the current one
  a_r7_fill_line: assert property (@(posedge clk) disable iff (!rstN)
    fillStrobe |-> (fillLine < lineNum));
endmodule

// File: rtl/scanline_slot_timer.sv
module scanline_slot_timer
  import scan_slot_pkg::*;
#(
  parameter int LINE_CLKS   = 3420,
  parameter int NTSC_ACTIVE = 225,
  parameter int PAL_ACTIVE  = 241,
  parameter int NTSC_FRAME  = 262,
  parameter int PAL_FRAME   = 313,
  parameter int LINE_W      = 9,
  parameter int SLOT_W      = 8,
  parameter int PIX_W       = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        modeReg2,
  input  logic [7:0]        modeReg4,
  input  logic [7:0]        bgColorReg,
  output logic [LINE_W-1:0] lineNum,
  output logic [SLOT_W-1:0] slotIdx,
  output logic              wideMode,
  output logic              palMode,
  output logic              renderSlot,
  output logic              refreshSlot,
  output logic              externalSlot,
  output logic              fillStrobe,
  output logic [LINE_W-1:0] fillLine,
  output logic [PIX_W-1:0]  fillX,
  output logic [5:0]        fillColor
);
  slot_strobe_t      strobe;
  logic [SLOT_W-1:0] slotCnt;
  logic [LINE_W-1:0] lineCnt;

  scan_slot_ctrl #(
    .LINE_CLKS(LINE_CLKS), .NTSC_FRAME(NTSC_FRAME), .PAL_FRAME(PAL_FRAME),
    .LINE_W(LINE_W), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeReg2(modeReg2), .modeReg4(modeReg4),
    .strobe(strobe), .slotCnt(slotCnt), .lineCnt(lineCnt)
  );

  scan_slot_datapath #(
    .LINE_W(LINE_W), .SLOT_W(SLOT_W), .PIX_W(PIX_W),
    .NTSC_ACTIVE(NTSC_ACTIVE), .PAL_ACTIVE(PAL_ACTIVE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotCnt(slotCnt),
    .lineCnt(lineCnt), .modeReg2(modeReg2), .bgColorReg(bgColorReg),
    .lineNum(lineNum), .slotIdx(slotIdx), .wideMode(wideMode),
    .palMode(palMode), .renderSlot(renderSlot), .refreshSlot(refreshSlot),
    .externalSlot(externalSlot), .fillStrobe(fillStrobe),
    .fillLine(fillLine), .fillX(fillX), .fillColor(fillColor)
  );
endmodule

// File: tb/scanline_slot_timer_tb.sv
module scanline_slot_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_CLKS  = 3420;
  localparam int NA = 3, PA = 4, NF = 5, PF = 6;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] modeReg2 = 8'h00, modeReg4 = 8'h00, bgColorReg = 8'h15;
  logic [8:0] lineNum, fillLine;
  logic [7:0] slotIdx;
  logic wideMode, palMode, renderSlot, refreshSlot, externalSlot, fillStrobe;
  logic [8:0] fillX;
  logic [5:0] fillColor;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scanline_slot_timer #(
    .NTSC_ACTIVE(NA), .PAL_ACTIVE(PA), .NTSC_FRAME(NF), .PAL_FRAME(PF)
  ) u_dut (
    .clk(clk), .rstN(rstN), .modeReg2(modeReg2), .modeReg4(modeReg4),
    .bgColorReg(bgColorReg), .lineNum(lineNum), .slotIdx(slotIdx),
    .wideMode(wideMode), .palMode(palMode), .renderSlot(renderSlot),
    .refreshSlot(refreshSlot), .externalSlot(externalSlot),
    .fillStrobe(fillStrobe), .fillLine(fillLine), .fillX(fillX),
    .fillColor(fillColor)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference model state and per-line statistics
  int mLc = 0, mLine = 0;
  bit mWide = 0, mPal = 0, predValid = 0, started = 0;
  int pSlot, pLine, pFillLine, pFillX, pColor;
  bit pWide, pPal, pRender, pRefresh, pExt, pFill;
  int curLine, curRender, curRefresh, curExt, curFill, curFirstX, curLastX, curFillLine;
  int doneSeq = 0, doneLine, doneRender, doneRefresh, doneExt, doneFill;
  int doneFirstX, doneLastX, doneFillLine;

  function automatic bit isRef(int slot, int base, int n);
    return slot >= base && slot <= base + 32 * (n - 1) && ((slot - base) % 32) == 0;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      predValid = 0; mLc = 0; mLine = 0; mWide = 0; mPal = 0; started = 0;
    end else begin
      if (predValid) begin
        chk("R1 lineNum", lineNum, pLine);
        chk("R2 slotIdx", slotIdx, pSlot);
        chk("R3 wideMode", wideMode, pWide);
        chk("R3 palMode", palMode, pPal);
        chk("R4 renderSlot", renderSlot, pRender);
        chk("R5 refreshSlot", refreshSlot, pRefresh);
        chk("R6 externalSlot", externalSlot, pExt);
        chk("R7 fillStrobe", fillStrobe, pFill);
        chk("R7 fillLine", fillLine, pFillLine);
        chk("R7 fillX", fillX, pFillX);
        chk("R7 fillColor", fillColor, pColor);
        if (renderSlot || refreshSlot || externalSlot) begin
          if (slotIdx == 0) begin
            if (started) begin
              doneLine = curLine; doneRender = curRender; doneRefresh = curRefresh;
              doneExt = curExt; doneFill = curFill; doneFirstX = curFirstX;
              doneLastX = curLastX; doneFillLine = curFillLine;
              doneSeq++;
            end
            started = 1;
            curLine = lineNum; curRender = 0; curRefresh = 0; curExt = 0;
            curFill = 0; curFirstX = -1; curLastX = -1; curFillLine = -1;
          end
          if (renderSlot) curRender++;
          if (refreshSlot) curRefresh++;
          if (externalSlot) curExt++;
          if (fillStrobe) begin
            curFill++;
            if (curFill == 1) curFirstX = fillX;
            curLastX = fillX;
            curFillLine = fillLine;
          end
        end
      end
      begin
        int w, slot, first, last;
        bit st, act, dis, rf;
        if (mLine == 0 && mLc == 0) begin
          mWide = modeReg4[0];
          mPal = modeReg2[3];
        end
        w = mWide ? 16 : 20;
        slot = mLc / w;
        st = (mLc % w) == 0;
        act = mLine < (mPal ? PA : NA);
        dis = modeReg2[6];
        rf = mWide ? isRef(slot, 73, 5) : isRef(slot, 66, 4);
        pSlot = slot; pLine = mLine; pWide = mWide; pPal = mPal;
        pRender = st && act && dis;
        pRefresh = st && !(act && dis) && rf;
        pExt = st && !(act && dis) && !rf;
        first = mWide ? 55 : 48;
        last = mWide ? 207 : 168;
        pFill = st && act && !dis && mLine > 0 && slot >= first && slot <= last
                && ((slot - first) % 8) == 0;
        pFillLine = pFill ? mLine - 1 : 0;
        pFillX = pFill ? (slot - first) * 2 : 0;
        pColor = pFill ? int'(bgColorReg[5:0]) : 0;
        mLc++;
        if (mLc == LINE_CLKS) begin
          mLc = 0;
          mLine = (mLine == (mPal ? PF : NF) - 1) ? 0 : mLine + 1;
        end
        predValid = 1;
      end
    end
  end

  task automatic nextLine();
    int s;
    s = doneSeq;
    wait (doneSeq != s);
  endtask

  task automatic setRegs(input logic [7:0] m2, input logic [7:0] m4, input logic [7:0] bg);
    @(posedge clk);
    #1;
    modeReg2 = m2; modeReg4 = m4; bgColorReg = bg;
  endtask

  task automatic testReset();
    repeat (4) @(negedge clk);
    chk("R8 reset lineNum", lineNum, 0);
    chk("R8 reset slotIdx", slotIdx, 0);
    chk("R8 reset pulses", {renderSlot, refreshSlot, externalSlot, fillStrobe}, 0);
    chk("R8 reset fill fields", fillLine + fillX + fillColor, 0);
    chk("R8 reset modes", {wideMode, palMode}, 0);
    @(posedge clk);
    #1;
    rstN = 1'b1;
  endtask

  task automatic testNarrowBlank();
    nextLine();
    chk("R1 first line", doneLine, 0);
    chk("R5 narrow refresh count", doneRefresh, 4);
    chk("R6 narrow external count", doneExt, 167);
    chk("R7 no fill on line 0", doneFill, 0);
    nextLine();
    chk("R7 narrow fill count", doneFill, 16);
    chk("R7 narrow first fillX", doneFirstX, 0);
    chk("R7 narrow last fillX", doneLastX, 240);
    chk("R7 fillLine is previous", doneFillLine, 0);
    nextLine();
    chk("R7 fillLine line 2", doneFillLine, 1);
    nextLine();
    chk("R4 blank line no fill", doneFill, 0);
    chk("R5 blank line refresh", doneRefresh, 4);
    nextLine();
    chk("R1 last NTSC line", doneLine, NF - 1);
  endtask

  task automatic testLatchHold();
    setRegs(8'h48, 8'h01, 8'h15);
    nextLine();
    chk("R1 NTSC wrap", doneLine, 0);
    nextLine();
    chk("R4 render count narrow", doneRender, 171);
    chk("R4 no refresh when rendering", doneRefresh + doneExt, 0);
    chk("R3 wide held mid-frame", wideMode, 0);
    chk("R3 PAL held mid-frame", palMode, 0);
    nextLine();
    nextLine();
    chk("R3 NTSC active count kept", doneRender, 0);
    chk("R6 blank external narrow", doneExt, 167);
    nextLine();
    nextLine();
    chk("R1 frame wrap before wide", doneLine, 0);
    chk("R2 wide render count", doneRender, 214);
    chk("R3 wide latched", wideMode, 1);
    chk("R3 PAL latched", palMode, 1);
    nextLine();
    nextLine();
    nextLine();
    chk("R4 PAL active line 3", doneRender, 214);
    nextLine();
    chk("R5 wide refresh count", doneRefresh, 5);
    chk("R6 wide external count", doneExt, 209);
    nextLine();
    chk("R1 PAL last line", doneLine, PF - 1);
  endtask

  task automatic testWideFill();
    setRegs(8'h08, 8'h01, 8'hFF);
    nextLine();
    chk("R1 PAL wrap", doneLine, 0);
    chk("R7 wide no fill on line 0", doneFill, 0);
    nextLine();
    chk("R7 wide fill count", doneFill, 20);
    chk("R7 wide first fillX", doneFirstX, 0);
    chk("R7 wide last fillX", doneLastX, 304);
    chk("R7 wide fillLine", doneFillLine, 0);
    chk("R9 wide classes sum", doneRefresh + doneExt + doneRender, 214);
  endtask

  initial begin
    testReset();
    testNarrowBlank();
    testLatchHold();
    testWideFill();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=finished", WATCHDOG);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule